// File: doc/BRIEF.md
# Read Port Controller with Fall-Through and Replay

This block is the read side of a FIFO. It takes a write pointer that has already been brought into the read clock domain and drives the address of the storage array. It holds the word presented to the consumer in an output register and reports one status flag. Two access modes are fixed when master reset is applied.

In fall-through mode, a word written into an empty queue moves to the output by itself, and the status flag means "word present". In standard mode, the output register changes only when a read request is accepted, and the status flag means "queue empty". A replay request moves the read pointer back to the origin (pointer value zero, where every reset leaves it), so that words already consumed are delivered again. Replay has two variants, also fixed at master reset. The zero-latency variant puts the origin word on the output in the very next cycle. The normal variant drops the output and refills it through the ordinary fall-through pipeline.

The storage array sits outside the block and has a combinational read port. Partial reset clears the pointers and the flag but keeps both mode selections.

Top module: `fwft_read_port`

## Requirements
- R1: `fwftSel` and `rtZeroSel` are sampled only in cycles where `mrst` is high. Changing them at any other time has no effect on behaviour.
- R2: Master reset and partial reset clear the read pointer, the write-pointer pipeline, the replay hold-off and the output register (`rdData` = 0). After either reset, `statusFlag` is 0 in fall-through mode and 1 in standard mode. Partial reset keeps the mode selections.
- R3: In standard mode (`fwftSel` = 0 at master reset), `rdData` changes only on an edge where `ren` is high and the queue holds an unread word, or on a replay edge. Words come out in write order. `statusFlag` is high while no unread word is available.
- R4: In standard mode, `statusFlag` falls two rising edges after the edge at which `wrPtr` advances from the value equal to the read pointer.
- R5: In fall-through mode (`fwftSel` = 1), the first word written into an empty queue is on `rdData` with `statusFlag` = 1 after the third rising edge following the `wrPtr` advance, with `ren` low.
- R6: In fall-through mode, an edge with `ren` high and `statusFlag` high consumes the current word. If another word is stored, it is on `rdData` right after that same edge, so reads can run back to back.
- R7: In fall-through mode, `statusFlag` falls at the edge that consumes the last stored word.
- R8: `ren` while no word is available (standard: empty; fall-through: `statusFlag` low) changes neither the pointer nor `rdData`.
- R9: Zero-latency replay (`rtZeroSel` = 1): after the edge with `rtReq` high, `rdData` holds the origin word. The next read returns the word after the origin. In fall-through mode `statusFlag` is 1.
- R10: Normal replay (`rtZeroSel` = 0): after the edge with `rtReq` high, no word is available for two more edges. In fall-through mode, the origin word is back on `rdData` with `statusFlag` = 1 after the third edge. In standard mode, `statusFlag` is high after the replay edge and the edge after it, and falls after the second edge following the replay edge.
- R11: When `rtReq` and `ren` are high in the same cycle, the replay takes effect and the read request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| mrst | input | 1 | Synchronous master reset, active high; samples the mode selects |
| prst | input | 1 | Synchronous partial reset, active high; modes kept |
| fwftSel | input | 1 | 1 selects fall-through mode, 0 standard mode (sampled at master reset) |
| rtZeroSel | input | 1 | 1 selects zero-latency replay, 0 normal replay (sampled at master reset) |
| wrPtr | input | ADDR_W+1 | Write pointer already synchronised to `clk`, with wrap bit |
| ren | input | 1 | Read request |
| rtReq | input | 1 | Replay request |
| ramRdAddr | output | ADDR_W | Read address to the storage array |
| ramRdData | input | DATA_W | Combinational read data from the storage array |
| rdData | output | DATA_W | Output data register |
| statusFlag | output | 1 | Fall-through: word present; standard: queue empty |

## Verification
Each result has a fixed due edge:
- In fall-through mode, a write pointer advance reaches the output on the third rising edge.
- In standard mode, it clears the empty flag on the second rising edge.
- An accepted read updates the output at the edge that accepts it.
- Zero-latency replay lands at the replay edge.
- Normal replay lands three edges later.

The bench drives every input just after a falling edge and samples just before the next falling edge. Each check is therefore placed after an exact count of rising edges from its stimulus, and the checks in between confirm that nothing arrived early. The same sequence runs for all four combinations of the two mode selects.

// File: rtl/rdport_pkg.sv
package rdport_pkg;

  // Strobes from the control path to the output datapath.
  typedef struct packed {
    logic load;      // capture array read data into the output register
    logic zeroLoad;  // address the origin instead of the read pointer
    logic clear;     // zero the output register
  } rdStrobe_t;

endpackage

// File: rtl/rdport_ctrl.sv
module rdport_ctrl
  import rdport_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int FWFT_LAT = 3
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              fwftSel,
  input  logic              rtZeroSel,
  input  logic [ADDR_W:0]   wrPtr,
  input  logic              ren,
  input  logic              rtReq,
  output rdStrobe_t         strobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              statusFlag,
  output logic              fwftModeO
);

  localparam int PTR_W  = ADDR_W + 1;
  localparam int HOLD_W = (FWFT_LAT > 2) ? $clog2(FWFT_LAT) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(FWFT_LAT - 1);
  localparam logic [PTR_W-1:0]  ORIGIN    = '0;

  logic              fwftMode;
  logic              zeroLatMode;
  logic [PTR_W-1:0]  wrQ1;
  logic [PTR_W-1:0]  wrQ2;
  logic [PTR_W-1:0]  rdPtr;
  logic [HOLD_W-1:0] holdCnt;
  logic              outValid;

  logic resetAny;
  logic haveWord;
  logic originFilled;
  logic zlHit;
  logic fwftLoad;
  logic stdLoad;
  logic normLoad;

  always_comb begin
    resetAny     = mrst || prst;
    haveWord     = (wrQ2 != rdPtr) && (holdCnt == '0);
    originFilled = (wrQ2 != ORIGIN);
    zlHit        = rtReq && zeroLatMode && originFilled;
    fwftLoad     = haveWord && (!outValid || ren);
    stdLoad      = ren && haveWord;
    normLoad     = !rtReq && (fwftMode ? fwftLoad : stdLoad);
  end

  always_comb begin
    strobe.load     = !resetAny && (normLoad || zlHit);
    strobe.zeroLoad = !resetAny && zlHit;
    strobe.clear    = resetAny;
  end

  // Mode selects are captured only during master reset.
  always_ff @(posedge clk) begin
    if (mrst) begin
      fwftMode    <= fwftSel;
      zeroLatMode <= rtZeroSel;
    end
  end

  always_ff @(posedge clk) begin
    if (resetAny) begin
      wrQ1     <= '0;
      wrQ2     <= '0;
      rdPtr    <= ORIGIN;
      holdCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      wrQ1 <= wrPtr;
      wrQ2 <= wrQ1;
      if (rtReq) begin
        if (zeroLatMode) begin
          rdPtr    <= originFilled ? ORIGIN + PTR_W'(1) : ORIGIN;
          outValid <= fwftMode && originFilled;
          holdCnt  <= '0;
        end else begin
          rdPtr    <= ORIGIN;
          outValid <= 1'b0;
          holdCnt  <= HOLD_LOAD;
        end
      end else begin
        if (holdCnt != '0) holdCnt <= holdCnt - HOLD_W'(1);
        if (normLoad) rdPtr <= rdPtr + PTR_W'(1);
        if (fwftMode) begin
          if (normLoad)  outValid <= 1'b1;
          else if (ren)  outValid <= 1'b0;
        end else begin
          outValid <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdAddr     = rdPtr[ADDR_W-1:0];
    statusFlag = fwftMode ? outValid : !haveWord;
    fwftModeO  = fwftMode;
  end

  assert_reset_clear_R2: assert property (@(posedge clk) disable iff (mrst)
    prst |=> (rdPtr == ORIGIN && !outValid && holdCnt == '0));

  assert_last_drop_R7: assert property (@(posedge clk) disable iff (resetAny)
    (fwftMode && outValid && ren && !rtReq && !haveWord) |=> !outValid);

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (resetAny)
    (!rtReq && !haveWord) |=> (rdPtr == $past(rdPtr)));

  assert_zero_lat_R9: assert property (@(posedge clk) disable iff (resetAny)
    (fwftMode && zeroLatMode && rtReq && originFilled)
      |=> (outValid && rdPtr == ORIGIN + PTR_W'(1)));

  assert_norm_replay_R10: assert property (@(posedge clk) disable iff (resetAny)
    (!zeroLatMode && rtReq) |=> (!outValid && rdPtr == ORIGIN && holdCnt != '0));

endmodule

// File: rtl/rdport_datapath.sv
module rdport_datapath
  import rdport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  rdStrobe_t         strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] ramRdAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] rdData
);

  always_comb begin
    ramRdAddr = strobe.zeroLoad ? '0 : rdAddr;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     rdData <= '0;
    else if (strobe.load) rdData <= ramRdData;
  end

  assert_load_excl_R2: assert property (@(posedge clk)
    strobe.clear |-> !strobe.load);

endmodule

// File: rtl/fwft_read_port.sv
module fwft_read_port
  import rdport_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int FWFT_LAT = 3
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              fwftSel,
  input  logic              rtZeroSel,
  input  logic [ADDR_W:0]   wrPtr,
  input  logic              ren,
  input  logic              rtReq,
  output logic [ADDR_W-1:0] ramRdAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              statusFlag
);

  rdStrobe_t         strobe;
  logic [ADDR_W-1:0] rdAddr;
  logic              fwftMode;

  rdport_ctrl #(.ADDR_W(ADDR_W), .FWFT_LAT(FWFT_LAT)) ctrl_i (
    .clk        (clk),
    .mrst       (mrst),
    .prst       (prst),
    .fwftSel    (fwftSel),
    .rtZeroSel  (rtZeroSel),
    .wrPtr      (wrPtr),
    .ren        (ren),
    .rtReq      (rtReq),
    .strobe     (strobe),
    .rdAddr     (rdAddr),
    .statusFlag (statusFlag),
    .fwftModeO  (fwftMode)
  );

  rdport_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .strobe    (strobe),
    .rdAddr    (rdAddr),
    .ramRdAddr (ramRdAddr),
    .ramRdData (ramRdData),
    .rdData    (rdData)
  );

  // Standard mode: no request and no replay means the output holds.
  assert_std_hold_R3: assert property (@(posedge clk) disable iff (mrst || prst)
    (!fwftMode && !ren && !rtReq) |=> $stable(rdData));

endmodule

// File: tb/fwft_read_port_tb_top.sv
`timescale 1ns/1ps
module fwft_read_port_tb_top;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              mrst, prst, fwftSel, rtZeroSel, ren, rtReq;
  logic [ADDR_W:0]   wrPtr;
  logic [ADDR_W-1:0] ramRdAddr;
  logic [DATA_W-1:0] ramRdData;
  logic [DATA_W-1:0] rdData;
  logic              statusFlag;
  logic [DATA_W-1:0] mem [DEPTH];

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  assign ramRdData = mem[ramRdAddr];

  fwft_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .mrst(mrst), .prst(prst), .fwftSel(fwftSel), .rtZeroSel(rtZeroSel),
    .wrPtr(wrPtr), .ren(ren), .rtReq(rtReq), .ramRdAddr(ramRdAddr),
    .ramRdData(ramRdData), .rdData(rdData), .statusFlag(statusFlag)
  );

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (fwft=%0b zl=%0b)", req, act, exp, fwftSel, rtZeroSel);
    end
  endtask

  function automatic logic [DATA_W-1:0] st(logic b);
    return {{(DATA_W-1){1'b0}}, b};
  endfunction

  task automatic runCfg(logic fs, logic rs);
    logic noWord;
    noWord = fs ? 1'b0 : 1'b1;
    mrst = 1'b1; prst = 1'b0; fwftSel = fs; rtZeroSel = rs;
    wrPtr = '0; ren = 1'b0; rtReq = 1'b0;
    edge1(); edge1();
    mrst = 1'b0;
    edge1();
    chk("R2 reset flag", st(statusFlag), st(noWord));
    chk("R2 reset data", rdData, '0);

    // R8: reads on an empty queue are dropped
    ren = 1'b1; edge1(); edge1(); ren = 1'b0;
    chk("R8 empty read flag", st(statusFlag), st(noWord));
    chk("R8 empty read data", rdData, '0);

    // First word into an empty queue
    wrPtr = 1;
    edge1();
    chk("R4 R5 edge1 flag", st(statusFlag), st(noWord));
    edge1();
    chk("R4 R5 edge2 flag", st(statusFlag), st(1'b0));
    edge1();
    if (fs) begin
      chk("R5 edge3 flag", st(statusFlag), st(1'b1));
      chk("R5 edge3 data", rdData, mem[0]);
    end else begin
      chk("R3 no read no data", rdData, '0);
    end
    ren = 1'b1; edge1(); ren = 1'b0;
    if (fs) chk("R7 last consumed", st(statusFlag), st(1'b0));
    else begin
      chk("R3 read data", rdData, mem[0]);
      chk("R3 empty again", st(statusFlag), st(1'b1));
    end

    // Burst of four words
    wrPtr = 5;
    edge1(); edge1(); edge1();
    if (fs) begin
      chk("R5 next word flag", st(statusFlag), st(1'b1));
      chk("R5 next word data", rdData, mem[1]);
      ren = 1'b1;
      for (int k = 2; k <= 4; k++) begin
        edge1();
        chk("R6 back to back", rdData, mem[k]);
        chk("R6 flag held", st(statusFlag), st(1'b1));
      end
      edge1();
      chk("R7 drain flag", st(statusFlag), st(1'b0));
    end else begin
      chk("R4 not empty", st(statusFlag), st(1'b0));
      ren = 1'b1;
      for (int k = 1; k <= 4; k++) begin
        edge1();
        chk("R3 ordered read", rdData, mem[k]);
      end
      chk("R3 drained", st(statusFlag), st(1'b1));
    end
    edge1(); edge1();
    ren = 1'b0;
    chk("R8 over-read data", rdData, mem[4]);
    chk("R8 over-read flag", st(statusFlag), st(noWord));

    // R1: selects changed outside master reset
    fwftSel = ~fs; rtZeroSel = ~rs;
    edge1(); edge1();
    chk("R1 flag unchanged", st(statusFlag), st(noWord));
    chk("R1 data unchanged", rdData, mem[4]);

    // Replay with a simultaneous read (R11)
    rtReq = 1'b1; ren = 1'b1;
    edge1();
    rtReq = 1'b0; ren = 1'b0;
    if (rs) begin
      chk("R9 R11 origin data", rdData, mem[0]);
      chk("R9 flag", st(statusFlag), st(fs ? 1'b1 : 1'b0));
    end else if (fs) begin
      chk("R10 R11 flag drop", st(statusFlag), st(1'b0));
      edge1();
      chk("R10 hold1", st(statusFlag), st(1'b0));
      edge1();
      chk("R10 hold2", st(statusFlag), st(1'b0));
      edge1();
      chk("R10 refill flag", st(statusFlag), st(1'b1));
      chk("R10 refill data", rdData, mem[0]);
    end else begin
      chk("R10 R11 data kept", rdData, mem[4]);
      chk("R10 empty during hold", st(statusFlag), st(1'b1));
      edge1();
      chk("R10 hold1", st(statusFlag), st(1'b1));
      edge1();
      chk("R10 ready", st(statusFlag), st(1'b0));
      ren = 1'b1; edge1(); ren = 1'b0;
      chk("R10 origin data", rdData, mem[0]);
    end
    ren = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      edge1();
      chk(rs ? "R9 replay order" : "R10 replay order", rdData, mem[k]);
    end
    ren = 1'b0;

    // Partial reset keeps the latched modes (selects still inverted)
    prst = 1'b1; wrPtr = '0;
    edge1();
    prst = 1'b0;
    chk("R2 partial flag", st(statusFlag), st(noWord));
    chk("R2 partial data", rdData, '0);
    wrPtr = 1;
    edge1(); edge1(); edge1();
    chk("R2 R1 mode kept flag", st(statusFlag), st(fs ? 1'b1 : 1'b0));
    chk("R2 R1 mode kept data", rdData, fs ? mem[0] : '0);
    fwftSel = fs; rtZeroSel = rs;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(i * 29 + 8'h5A);
    mrst = 1'b1; prst = 1'b0; fwftSel = 1'b0; rtZeroSel = 1'b0;
    wrPtr = '0; ren = 1'b0; rtReq = 1'b0;
    @(negedge clk);
    for (int cfg = 0; cfg < 4; cfg++) runCfg(cfg[0], cfg[1]);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule